// File: doc/BRIEF.md
# Multi-Compare General Purpose Timer

This block is a memory-mapped up-counting timer with three compare channels and a single level-sensitive interrupt. Software selects a count source from a fast and a slow clock enable, divides it with a 12-bit prescaler, and reads the running count back through a single-cycle register port. Each compare channel raises a status flag when the counter reaches its value, and a further flag marks the wrap from all ones to zero. Status flags clear when software writes a one to them. Each flag can drive the interrupt through its own enable bit.

Two counting styles are offered. In free-run mode the counter runs through its whole range. In restart mode compare channel 1 sets the period: the counter returns to zero after it matches, and a write to that compare register also restarts the count. A software reset bit returns the block to its power-on state. It keeps the clock-select and mode fields that are written with it. The two capture registers are placeholders that always read back as zero.

Top module: `mctimer`

## Requirements
- R1: The word offset is address bits [ADDR_W-1:2]. Offset 0 is control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, 7/8 capture 1/2 and 9 counter. Capture offsets and offsets above 9 read zero. Writes to offsets 7 to 9 and above 9 change nothing.
- R2: Control bits under mask 0x7C14 are not stored and read as zero. All other written control bits read back.
- R3: After hard reset, control, prescaler, status, interrupt enable and counter read zero, and every compare register reads all ones.
- R4: Control bits [8:6] select the source. Code 1 or 2 counts on clk_main_en, code 4 counts on clk_slow_en, and any other code stops counting.
- R5: The prescaler is 12 bits wide. The counter advances once per (prescaler + 1) qualifying source enables.
- R6: Control bit 0 enables counting. If bit 0 is set by a write that also sets bit 1 while the timer is stopped, the counter and prescaler restart from zero. Otherwise the counter resumes from its held value. While bit 0 is clear the counter holds.
- R7: On the step where the counter reaches the value of compare N (N = 1..3), status bit N-1 is set.
- R8: With control bit 9 clear (restart mode), the step after the counter equals compare 1 returns it to zero, and a write to compare 1 clears the counter. With bit 9 set, a write to compare 1 leaves the counter alone.
- R9: When the counter wraps from all ones to zero, status bit 5 is set.
- R10: Writing status with a one in any of bits [5:0] clears that flag. A zero bit leaves the flag unchanged.
- R11: irq is high only when control bit 0 is set and some status bit is set together with the same bit of the interrupt enable register (6 bits, same layout as status).
- R12: A control write with bit 15 set resets prescaler, status, interrupt enable, counter and compares to their reset values. It stores the written control value with bits [5:0] cleared. Bit 15 reads back set for one cycle and then clears by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| clk_main_en | input | 1 | Fast count-source enable |
| clk_slow_en | input | 1 | Slow count-source enable |
| addr | input | ADDR_W | Byte address of the register port |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt |

## Verification
The count path is driven with bursts of an exact number of source enables. This makes every readback a known integer, so an off-by-one in the prescaler or in the enable path shows up as a wrong count. Bursts on the unselected source and on an unused code show that source selection is honoured. The restart-mode bursts cross the compare-1 value, which tells a counter that returns to zero from one that keeps counting or returns one step early. A free-run burst of the same shape, followed by a compare write, tells the two modes apart. An 8-bit-wide instance runs through its whole range so that the wrap flag is observed at the exact step where it occurs. Status clearing is tried with zero writes, partial writes and full writes, each followed by a look at the interrupt line.

// File: rtl/mctimer.sv
module mctimer #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12,
  parameter int PRE_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_main_en,
  input  logic              clk_slow_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              irq
);
  localparam logic [31:0] CTRL_NOSTORE = 32'h0000_7C14;
  localparam logic [31:0] CTRL_SRST_CLR = 32'h0000_003F;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int NCMP = 3;

  logic [31:0]      ctrl;
  logic [PRE_W-1:0] presc, pcnt;
  logic [5:0]       status, ie;
  logic [CNT_W-1:0] cmp [NCMP];
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic [ADDR_W-3:0] off;
  logic             src_tick, tick, step, srst, restart;
  logic [NCMP-1:0]  hit;
  logic [5:0]       set_flags, clr_flags;

  wire en    = ctrl[0];
  wire enmod = ctrl[1];
  wire frr   = ctrl[9];

  assign off = addr[ADDR_W-1:2];

  function automatic logic sel(input int k);
    return wr_en && (int'(off) == k);
  endfunction

  always_comb begin
    case (ctrl[8:6])
      3'd1, 3'd2: src_tick = clk_main_en;
      3'd4:       src_tick = clk_slow_en;
      default:    src_tick = 1'b0;
    endcase
  end

  assign tick    = en && src_tick;
  assign step    = tick && (pcnt >= presc);
  assign cnt_nxt = ((!frr && cnt == cmp[0]) || cnt == CNT_MAX) ? '0 : cnt + 1'b1;

  for (genvar i = 0; i < NCMP; i++) begin : g_hit
    assign hit[i] = step && (cnt_nxt == cmp[i]);
  end

  assign set_flags = {step && (cnt == CNT_MAX), 2'b00, hit};
  assign clr_flags = sel(2) ? wr_data[5:0] : 6'd0;
  assign srst      = sel(0) && wr_data[15];
  assign restart   = (sel(0) && !en && wr_data[0] && wr_data[1]) || (sel(4) && !frr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      presc  <= '0;
      pcnt   <= '0;
      status <= '0;
      ie     <= '0;
      cnt    <= '0;
      for (int i = 0; i < NCMP; i++) cmp[i] <= CNT_MAX;
    end else if (srst) begin
      ctrl   <= wr_data & ~CTRL_NOSTORE & ~CTRL_SRST_CLR;
      presc  <= '0;
      pcnt   <= '0;
      status <= '0;
      ie     <= '0;
      cnt    <= '0;
      for (int i = 0; i < NCMP; i++) cmp[i] <= CNT_MAX;
    end else begin
      if (ctrl[15]) ctrl[15] <= 1'b0;
      if (sel(0)) ctrl <= wr_data & ~CTRL_NOSTORE;
      if (sel(1)) presc <= wr_data[PRE_W-1:0];
      if (sel(3)) ie <= wr_data[5:0];
      for (int i = 0; i < NCMP; i++)
        if (sel(4 + i)) cmp[i] <= wr_data[CNT_W-1:0];
      status <= (status & ~clr_flags) | set_flags;
      if (restart) begin
        cnt  <= '0;
        pcnt <= '0;
      end else if (step) begin
        cnt  <= cnt_nxt;
        pcnt <= '0;
      end else if (tick) begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (int'(off))
      0:       rd_data = ctrl;
      1:       rd_data = 32'(presc);
      2:       rd_data = 32'(status);
      3:       rd_data = 32'(ie);
      4:       rd_data = 32'(cmp[0]);
      5:       rd_data = 32'(cmp[1]);
      6:       rd_data = 32'(cmp[2]);
      9:       rd_data = 32'(cnt);
      default: rd_data = '0;
    endcase
  end

  assign irq = en && |(status & ie);
endmodule

// File: rtl/mctimer_chk.sv
module mctimer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [31:0]      ctrl,
  input logic [5:0]       status,
  input logic [5:0]       ie,
  input logic [CNT_W-1:0] cnt,
  input logic             irq
);
  p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |-> !irq);

  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & ie) != 6'd0));

  p_hold_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !wr_en) |=> $stable(cnt));

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt == '0 || cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  p_flags_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((status & $past(status)) == $past(status)));

  p_srst_selfclear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[15] && !wr_en) |=> !ctrl[15]);
endmodule

bind mctimer mctimer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctrl(ctrl),
  .status(status), .ie(ie), .cnt(cnt), .irq(irq)
);

// File: tb/mctimer_tb_top.sv
module mctimer_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 12;

  logic clk = 1'b0, rst_n = 1'b0, main_en = 1'b0, slow_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data, rd_small;
  logic irq, irq_small;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  mctimer #(.CNT_W(32), .ADDR_W(AW), .PRE_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_main_en(main_en), .clk_slow_en(slow_en),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  mctimer #(.CNT_W(8), .ADDR_W(AW), .PRE_W(12)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .clk_main_en(main_en), .clk_slow_en(slow_en),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_small), .irq(irq_small));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(int off, logic [31:0] d);
    @(negedge clk);
    addr = AW'(off * 4); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string req, int off, logic [31:0] exp);
    @(negedge clk);
    addr = AW'(off * 4); #1;
    check(req, rd_data, exp);
  endtask

  task automatic pulse_main(int n);
    @(negedge clk); main_en = 1'b1;
    repeat (n) @(negedge clk);
    main_en = 1'b0;
  endtask

  task automatic pulse_slow(int n);
    @(negedge clk); slow_en = 1'b1;
    repeat (n) @(negedge clk);
    slow_en = 1'b0;
  endtask

  task automatic t_reset;
    rd("R3 ctrl", 0, 0);
    rd("R3 presc", 1, 0);
    rd("R3 status", 2, 0);
    rd("R3 ie", 3, 0);
    for (int i = 4; i <= 6; i++) rd("R3 compare", i, 32'hFFFF_FFFF);
    rd("R3 counter", 9, 0);
    rd("R1 capture1", 7, 0);
    rd("R1 capture2", 8, 0);
    check("R11 irq at reset", {31'd0, irq}, 0);
  endtask

  task automatic t_ctrl_mask;
    wr(0, 32'hFFFF_7FFF);
    rd("R2 ctrl mask", 0, 32'hFFFF_03EB);
    wr(0, 0);
    rd("R2 ctrl clear", 0, 0);
  endtask

  task automatic t_map;
    wr(3, 32'h15);
    wr(10, 32'h3F);
    wr(7, 32'h1234);
    wr(9, 32'h55);
    rd("R1 ie kept", 3, 32'h15);
    rd("R1 capture write ignored", 7, 0);
    rd("R1 counter write ignored", 9, 0);
    rd("R1 unknown offset", 10, 0);
    wr(3, 0);
  endtask

  task automatic t_presc;
    wr(1, 0); wr(0, 32'h243);
    pulse_main(9);
    rd("R5 div1 count", 9, 9);
    wr(0, 32'h240); wr(1, 3); wr(0, 32'h243);
    pulse_main(20);
    rd("R5 div4 count", 9, 5);
    wr(1, 0);
  endtask

  task automatic t_clksrc;
    wr(0, 0); wr(0, 32'h103);
    pulse_main(10);
    rd("R4 slow ignores main", 9, 0);
    pulse_slow(7);
    rd("R4 slow source", 9, 7);
    wr(0, 0); wr(0, 32'h083);
    pulse_main(3);
    rd("R4 code 2 main", 9, 3);
    wr(0, 0); wr(0, 32'h0C3);
    pulse_main(5);
    pulse_slow(5);
    rd("R4 code 3 no clock", 9, 0);
  endtask

  task automatic t_enmod;
    wr(0, 0); wr(0, 32'h243);
    pulse_main(5);
    wr(0, 32'h240);
    pulse_main(4);
    rd("R6 freeze", 9, 5);
    wr(0, 32'h241);
    pulse_main(3);
    rd("R6 resume", 9, 8);
    wr(0, 32'h240); wr(0, 32'h243);
    rd("R6 restart", 9, 0);
  endtask

  task automatic t_compare_irq;
    wr(0, 0); wr(2, 32'h3F);
    wr(5, 10); wr(6, 3); wr(3, 32'h02);
    wr(0, 32'h243);
    pulse_main(3);
    rd("R7 compare3 flag", 2, 32'h04);
    check("R11 irq masked", {31'd0, irq}, 0);
    pulse_main(7);
    rd("R7 compare2 flag", 2, 32'h06);
    check("R11 irq raised", {31'd0, irq}, 1);
    wr(2, 0);
    rd("R10 zero write", 2, 32'h06);
    wr(2, 32'h04);
    rd("R10 one clears", 2, 32'h02);
    check("R11 irq still", {31'd0, irq}, 1);
    wr(0, 32'h240);
    #1 check("R11 irq off when disabled", {31'd0, irq}, 0);
    wr(2, 32'h02);
    rd("R10 cleared", 2, 0);
    wr(5, 32'hFFFF_FFFF); wr(6, 32'hFFFF_FFFF); wr(3, 0);
  endtask

  task automatic t_restart;
    wr(0, 0); wr(2, 32'h3F);
    wr(0, 32'h043);
    pulse_main(3);
    rd("R8 pre", 9, 3);
    wr(4, 4);
    rd("R8 compare1 write restarts", 9, 0);
    pulse_main(5);
    rd("R8 wrap at compare1", 9, 0);
    rd("R7 compare1 flag", 2, 32'h01);
    pulse_main(7);
    rd("R8 period", 9, 2);
    wr(0, 32'h240); wr(0, 32'h243);
    pulse_main(6);
    wr(4, 2);
    rd("R8 free-run no restart", 9, 6);
    wr(4, 32'hFFFF_FFFF); wr(2, 32'h3F);
  endtask

  task automatic t_rollover;
    wr(0, 0); wr(2, 32'h3F); wr(3, 32'h20);
    wr(0, 32'h243);
    pulse_main(255);
    @(negedge clk); addr = AW'(9 * 4); #1;
    check("R9 small at max", rd_small, 255);
    addr = AW'(2 * 4); #1;
    check("R9 no wrap yet", rd_small & 32'h20, 0);
    check("R11 small irq low", {31'd0, irq_small}, 0);
    pulse_main(1);
    addr = AW'(9 * 4); #1;
    check("R9 small wrapped", rd_small, 0);
    addr = AW'(2 * 4); #1;
    check("R9 wrap flag", rd_small & 32'h20, 32'h20);
    check("R9 wide no wrap", rd_data & 32'h20, 0);
    check("R11 small irq high", {31'd0, irq_small}, 1);
    wr(0, 0); wr(2, 32'h3F); wr(3, 0);
  endtask

  task automatic t_softreset;
    wr(1, 7); wr(3, 32'h3F); wr(5, 32'h55);
    wr(0, 32'h243);
    pulse_main(8);
    wr(0, 32'h83C3);
    addr = 0; #1;
    check("R12 reset bit visible", rd_data, 32'h83C0);
    rd("R12 reset bit self-clears", 0, 32'h03C0);
    rd("R12 presc", 1, 0);
    rd("R12 ie", 3, 0);
    rd("R12 compare2", 5, 32'hFFFF_FFFF);
    rd("R12 counter", 9, 0);
    rd("R12 status", 2, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl_mask();
    t_map();
    t_presc();
    t_clksrc();
    t_enmod();
    t_compare_irq();
    t_restart();
    t_rollover();
    t_softreset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule